// File: doc/BRIEF.md
# Predicated Run Sequencer

This block sits in a processor decode stage and follows the short run of predicated instructions that an if-then prefix opens. When the prefix is decoded, the block records three things: the prefix's base condition, how many slots follow (one to four), and a then/else pattern for the slots after the first. For each following instruction it presents the condition that slot must meet. That condition is the base condition for a "then" slot and its inverse for an "else" slot.

The block also decides whether the instruction in the current slot executes or is skipped. It evaluates the slot condition against the N, Z, C and V flags as they stand in that cycle. An instruction inside the run that updates the flags therefore changes the decision for the slots after it.

The block also enforces the rules of the run, and raises a one-cycle error pulse in three cases:
- a retiring instruction carries no condition code;
- a retiring instruction carries a code that differs from its slot's condition;
- a branch retires in any slot other than the final one.

A flush or reset abandons the run at once. Fetch, full decode and flag writeback stay outside the block.

Top module: `ite_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves any run. After that edge `in_block` = 0, `rule_error` = 0 and `execute` = 1.
- R2: `prefix_valid` at an edge opens a run of `prefix_last`+1 slots (1 to 4). From the next cycle `in_block` = 1 and `slot_index` = 0, and slot 0 always uses `prefix_cond` unchanged.
- R3: Slot k (k = 1..3) is an else slot when `prefix_else[k-1]` = 1, and a then slot when that bit is 0. An else slot presents `prefix_cond` with bit 0 inverted on `slot_condition`. A then slot presents `prefix_cond` unchanged. `slot_condition` and `slot_index` hold while no instruction retires.
- R4: Each edge with `instr_valid` = 1 inside a run advances `slot_index` by one. After the last slot retires, `in_block` is 0 from the next cycle.
- R5: Conditions use a 4-bit code, with the predicate selected by bits [3:1]: 0 = Z, 1 = C, 2 = N, 3 = V, 4 = C and not Z, 5 = (N == V), 6 = not Z and (N == V), 7 = always true. For codes 0 to 13, bit 0 = 1 inverts the predicate; codes 14 and 15 are always true. Inside a run, `execute` is the slot condition evaluated on the flag inputs. Outside a run, `execute` = 1.
- R6: `execute` follows the flag inputs in the same cycle, so flags changed by an earlier slot of the run decide the later slots.
- R7: A branch (`instr_is_branch` = 1) that retires inside a run in a slot other than the last one sets `rule_error` = 1 in the following cycle. A branch in the last slot, or a branch outside any run, leaves `rule_error` at 0.
- R8: A retiring instruction inside a run with `instr_has_cond` = 0, or with `instr_cond` different from `slot_condition`, sets `rule_error` for exactly the following cycle.
- R9: `flush` at an edge ends any run, so `in_block` = 0 in the next cycle. `flush` takes priority over `prefix_valid` and over a retiring instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Pipeline flush; abandons the current run |
| prefix_valid | input | 1 | An if-then prefix is decoded this cycle |
| prefix_cond | input | 4 | Base condition code of the prefix |
| prefix_last | input | 2 | Number of covered slots minus one |
| prefix_else | input | 3 | Then/else pattern for slots 1..3 (bit k-1 is slot k, 1 = else) |
| instr_valid | input | 1 | An instruction retires from the current slot |
| instr_has_cond | input | 1 | The instruction carries a condition code |
| instr_cond | input | 4 | Condition code carried by the instruction |
| instr_is_branch | input | 1 | The instruction is a branch |
| flag_n | input | 1 | Live negative flag |
| flag_z | input | 1 | Live zero flag |
| flag_c | input | 1 | Live carry flag |
| flag_v | input | 1 | Live overflow flag |
| in_block | output | 1 | A predicated run is active |
| slot_index | output | 2 | Position of the current slot in the run |
| slot_condition | output | 4 | Condition the current slot must meet |
| execute | output | 1 | 1 = execute the current instruction, 0 = skip it |
| rule_error | output | 1 | One-cycle pulse after an illegal instruction in a run |

## Verification
Several properties are checked on every cycle:
- `execute` is 1 whenever no run is active.
- A prefix opens a run at slot 0.
- A flush closes the run.
- Slot state holds while nothing retires.
- An error pulse only follows a retiring instruction.

The bench scenarios cover what the per-cycle properties cannot. These are:
- the value of each condition code under chosen flag sets;
- the then/else mapping across a four-slot pattern;
- the execute decision changing as the flags change in the middle of a run;
- which specific violations raise `rule_error`, and that legal branches in the last slot raise nothing.

// File: rtl/ite_pkg.sv
// Shared definitions for the predicated run sequencer.
// Holds the condition code width and the condition evaluation function.
// Assumes the 4-bit code layout: bits [3:1] pick the predicate, bit 0 inverts it.
package ite_pkg;

    localparam int COND_W = 4;

    // Decide whether a condition code holds for the given flags.
    function automatic logic cond_holds(
        input logic [COND_W-1:0] code,
        input logic              n,
        input logic              z,
        input logic              c,
        input logic              v
    );
        logic base;
        case (code[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        if (code[3:1] != 3'd7 && code[0]) begin
            return ~base;
        end
        return base;
    endfunction

endpackage

// File: rtl/ite_slot_tracker.sv
// Holds the state of an open predicated run: the remaining-slot mask,
// the then/else mask, the base condition and the current slot index.
// Both masks shift right by one slot per retired instruction. Bit 0 is the
// current slot. Assumes MAX_SLOTS >= 2.
module ite_slot_tracker #(
    parameter int MAX_SLOTS = 4,
    parameter int IDX_W     = $clog2(MAX_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      load,
    input  logic [ite_pkg::COND_W-1:0] load_cond,
    input  logic [IDX_W-1:0]          load_last,
    input  logic [MAX_SLOTS-2:0]      load_else,
    input  logic                      advance,
    output logic                      active,
    output logic                      last_slot,
    output logic [IDX_W-1:0]          index,
    output logic [ite_pkg::COND_W-1:0] cond
);
    import ite_pkg::*;

    logic [MAX_SLOTS-1:0] live_q;
    logic [MAX_SLOTS-1:0] else_q;
    logic [COND_W-1:0]    base_q;
    logic [IDX_W-1:0]     idx_q;
    logic [MAX_SLOTS-1:0] live_load;

    // Build the remaining-slot mask for a new run: one bit per covered slot.
    always_comb begin
        for (int i = 0; i < MAX_SLOTS; i++) begin
            live_load[i] = (IDX_W'(i) <= load_last);
        end
    end

    // Update the run state: reset, flush, new prefix, or advance one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            else_q <= '0;
            base_q <= '0;
            idx_q  <= '0;
        end else if (flush) begin
            live_q <= '0;
            else_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            live_q <= live_load;
            else_q <= {load_else, 1'b0};
            base_q <= load_cond;
            idx_q  <= '0;
        end else if (advance && live_q[0]) begin
            live_q <= {1'b0, live_q[MAX_SLOTS-1:1]};
            else_q <= {1'b0, else_q[MAX_SLOTS-1:1]};
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Present the current slot: active flag, last-slot flag, condition.
    always_comb begin
        active    = live_q[0];
        last_slot = live_q[0] & ~live_q[1];
        index     = idx_q;
        cond      = base_q ^ {{(COND_W-1){1'b0}}, else_q[0]};
    end

endmodule

// File: rtl/ite_cond_unit.sv
// Evaluates one condition code against the live flags.
// Purely combinational. Assumes the flags are already settled in this cycle.
module ite_cond_unit (
    input  logic [ite_pkg::COND_W-1:0] cond,
    input  logic                       n,
    input  logic                       z,
    input  logic                       c,
    input  logic                       v,
    output logic                       holds
);
    import ite_pkg::*;

    // Apply the shared evaluation function.
    always_comb begin
        holds = cond_holds(cond, n, z, c, v);
    end

endmodule

// File: rtl/ite_rule_check.sv
// Flags illegal instructions inside a predicated run. The three cases are:
// a missing condition code, a code other than the slot's own, and a branch
// before the last slot. The result is registered and lasts one cycle.
// Assumes the slot inputs describe the slot the instruction retires from.
module ite_rule_check (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_run,
    input  logic                       last_slot,
    input  logic [ite_pkg::COND_W-1:0] slot_cond,
    input  logic                       retire,
    input  logic                       has_cond,
    input  logic [ite_pkg::COND_W-1:0] instr_cond,
    input  logic                       is_branch,
    output logic                       err
);
    logic bad_now;

    // Combine the three violation cases for the retiring instruction.
    always_comb begin
        bad_now = retire && in_run &&
                  (!has_cond || (instr_cond != slot_cond) || (is_branch && !last_slot));
    end

    // Register the violation into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= bad_now;
        end
    end

endmodule

// File: rtl/ite_sequencer.sv
// Top of the predicated run sequencer. It joins three parts:
// - the slot tracker, which keeps the run state;
// - the condition unit, which makes the execute decision;
// - the rule checker, which raises error pulses.
// Outside a run every instruction executes. Assumes at most one prefix or one
// retiring instruction is presented per cycle.
module ite_sequencer #(
    parameter int MAX_SLOTS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic                               prefix_valid,
    input  logic [3:0]                         prefix_cond,
    input  logic [$clog2(MAX_SLOTS)-1:0]       prefix_last,
    input  logic [MAX_SLOTS-2:0]               prefix_else,
    input  logic                               instr_valid,
    input  logic                               instr_has_cond,
    input  logic [3:0]                         instr_cond,
    input  logic                               instr_is_branch,
    input  logic                               flag_n,
    input  logic                               flag_z,
    input  logic                               flag_c,
    input  logic                               flag_v,
    output logic                               in_block,
    output logic [$clog2(MAX_SLOTS)-1:0]       slot_index,
    output logic [3:0]                         slot_condition,
    output logic                               execute,
    output logic                               rule_error
);
    localparam int IDX_W = $clog2(MAX_SLOTS);

    logic active;
    logic last_slot;
    logic holds;

    ite_slot_tracker #(
        .MAX_SLOTS (MAX_SLOTS),
        .IDX_W     (IDX_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load      (prefix_valid),
        .load_cond (prefix_cond),
        .load_last (prefix_last),
        .load_else (prefix_else),
        .advance   (instr_valid),
        .active    (active),
        .last_slot (last_slot),
        .index     (slot_index),
        .cond      (slot_condition)
    );

    ite_cond_unit u_cond (
        .cond  (slot_condition),
        .n     (flag_n),
        .z     (flag_z),
        .c     (flag_c),
        .v     (flag_v),
        .holds (holds)
    );

    ite_rule_check u_rules (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_run     (active),
        .last_slot  (last_slot),
        .slot_cond  (slot_condition),
        .retire     (instr_valid),
        .has_cond   (instr_has_cond),
        .instr_cond (instr_cond),
        .is_branch  (instr_is_branch),
        .err        (rule_error)
    );

    // Drive the run flag and the execute decision; outside a run always execute.
    always_comb begin
        in_block = active;
        execute  = active ? holds : 1'b1;
    end

endmodule

// File: rtl/ite_sequencer_checker.sv
// Per-cycle properties of the predicated run sequencer, bound to its top.
// Assumes the port names of ite_sequencer.
module ite_sequencer_checker #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             prefix_valid,
    input logic             instr_valid,
    input logic             in_block,
    input logic [IDX_W-1:0] slot_index,
    input logic [3:0]       slot_condition,
    input logic             execute,
    input logic             rule_error
);

    assert_idle_executes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block |-> execute);

    assert_prefix_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prefix_valid && !flush) |=> (in_block && slot_index == '0));

    assert_slot_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block && !instr_valid && !prefix_valid && !flush)
        |=> ($stable(slot_condition) && $stable(slot_index) && in_block));

    assert_flush_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !in_block);

    assert_err_after_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rule_error |-> $past(instr_valid));

endmodule

bind ite_sequencer ite_sequencer_checker #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/ite_sequencer_bench.sv
// Self-checking bench for ite_sequencer: a table of single-slot condition
// vectors, followed by directed runs for patterns, rules, flush and reset.
module ite_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    // Each entry: {cond[3:0], n, z, c, v, expected execute}
    localparam logic [8:0] VEC [16] = '{
        9'b0000_0100_1, 9'b0001_0100_0, 9'b0010_0010_1, 9'b0011_0010_0,
        9'b0100_1000_1, 9'b0101_1000_0, 9'b0110_0000_0, 9'b0111_0000_1,
        9'b1000_0010_1, 9'b1001_0110_1, 9'b1010_1000_0, 9'b1011_1000_1,
        9'b1100_1001_1, 9'b1101_1001_0, 9'b1110_0000_1, 9'b1000_0000_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       prefix_valid = 1'b0;
    logic [3:0] prefix_cond = '0;
    logic [1:0] prefix_last = '0;
    logic [2:0] prefix_else = '0;
    logic       instr_valid = 1'b0;
    logic       instr_has_cond = 1'b0;
    logic [3:0] instr_cond = '0;
    logic       instr_is_branch = 1'b0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic       in_block, execute, rule_error;
    logic [1:0] slot_index;
    logic [3:0] slot_condition;

    int checks = 0;
    int errors = 0;
    logic       s_exe;
    logic [3:0] s_cond;
    logic [1:0] s_idx;

    ite_sequencer u_ite_sequencer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one comparison and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a prefix for one edge.
    task automatic open_run(input logic [3:0] c, input logic [1:0] last, input logic [2:0] els);
        prefix_valid = 1'b1; prefix_cond = c; prefix_last = last; prefix_else = els;
        @(negedge clk);
        prefix_valid = 1'b0;
        #1;
    endtask

    // Retire one instruction; samples slot outputs before the edge.
    task automatic retire(input logic has, input logic [3:0] c, input logic br, input logic [3:0] nzcv);
        instr_valid = 1'b1; instr_has_cond = has; instr_cond = c; instr_is_branch = br;
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
        #1;
        s_exe = execute; s_cond = slot_condition; s_idx = slot_index;
        @(negedge clk);
        instr_valid = 1'b0; instr_is_branch = 1'b0;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 in_block", in_block, 0);
        chk("R1 rule_error", rule_error, 0);
        chk("R1 execute", execute, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R5 table walk: single-slot runs
        for (int i = 0; i < 16; i++) begin
            open_run(VEC[i][8:5], 2'd0, 3'b000);
            chk("R2 open", in_block, 1);
            retire(1'b1, VEC[i][8:5], 1'b0, VEC[i][4:1]);
            chk("R5 execute", s_exe, VEC[i][0]);
            chk("R2 slot0 cond", s_cond, VEC[i][8:5]);
            chk("R4 closed", in_block, 0);
            chk("R8 legal no error", rule_error, 0);
        end

        // R3/R4/R6: then,then,else,else on EQ with flags changing mid-run
        open_run(4'd0, 2'd3, 3'b110);
        retire(1'b1, 4'd0, 1'b0, 4'b0100);
        chk("R4 idx0", s_idx, 0); chk("R3 slot0 cond", s_cond, 0); chk("R6 exe0", s_exe, 1);
        retire(1'b1, 4'd0, 1'b0, 4'b0000);
        chk("R4 idx1", s_idx, 1); chk("R3 slot1 cond", s_cond, 0); chk("R6 exe1 flag change", s_exe, 0);
        chk("R3 hold", slot_index, 2);
        @(negedge clk); #1;
        chk("R3 hold idle", slot_index, 2); chk("R3 hold cond", slot_condition, 1);
        retire(1'b1, 4'd1, 1'b0, 4'b0000);
        chk("R4 idx2", s_idx, 2); chk("R3 slot2 else", s_cond, 1); chk("R6 exe2", s_exe, 1);
        retire(1'b1, 4'd1, 1'b1, 4'b0100);
        chk("R4 idx3", s_idx, 3); chk("R3 slot3 else", s_cond, 1); chk("R6 exe3", s_exe, 0);
        chk("R7 last branch ok", rule_error, 0);
        chk("R4 run ends", in_block, 0);

        // R7: branch in a non-final slot
        open_run(4'd10, 2'd1, 3'b000);
        retire(1'b1, 4'd10, 1'b1, 4'b0000);
        chk("R7 early branch", rule_error, 1);
        @(negedge clk); #1;
        chk("R8 pulse one cycle", rule_error, 0);
        retire(1'b1, 4'd10, 1'b0, 4'b0000);
        chk("R7 run closes", in_block, 0);

        // R7: branch outside any run
        retire(1'b0, 4'd0, 1'b1, 4'b0000);
        chk("R7 outside branch", rule_error, 0);
        chk("R5 outside execute", s_exe, 1);

        // R8: missing condition and mismatched condition
        open_run(4'd2, 2'd1, 3'b001);
        retire(1'b0, 4'd2, 1'b0, 4'b0000);
        chk("R8 missing cond", rule_error, 1);
        retire(1'b1, 4'd2, 1'b0, 4'b0000);
        chk("R8 mismatch (else wants 3)", rule_error, 1);
        chk("R4 mismatch run ends", in_block, 0);

        // R9: flush mid-run, also against a simultaneous prefix
        open_run(4'd4, 2'd3, 3'b000);
        retire(1'b1, 4'd4, 1'b0, 4'b0000);
        flush = 1'b1; prefix_valid = 1'b1;
        @(negedge clk);
        flush = 1'b0; prefix_valid = 1'b0;
        #1;
        chk("R9 flush closes", in_block, 0);
        chk("R9 execute after flush", execute, 1);

        // R1: reset mid-run
        open_run(4'd6, 2'd2, 3'b000);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1 reset closes run", in_block, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule